// File: doc/BRIEF.md
# Trace Message Slice Packer

The block turns one trace message request into a stream of 8-bit output words. A request carries a 6-bit type code, up to two short fixed-width fields and up to three variable-length values of up to 64 bits each. Each output word holds a 6-bit data slice in bits 5:0 and a 2-bit boundary marker in bits 7:6. The type code and the fixed fields are packed back to back, least significant bit first, and they may share slices. Each variable value starts on a new slice and uses only as many slices as its highest set bit needs. Boundaries between fields are shown by the markers, so the message carries no length header.

A producer presents a request with `in_valid`. The packer takes it when `in_ready` is high and keeps `in_ready` low until the last word of that message has been taken downstream. The output follows valid/ready: a word stays on `out_word` until `out_ready` takes it. Typical fixed fields are a 4-bit sync reason, a 2-bit branch kind or a 4-bit resource code. Typical variable values are instruction counts, addresses, branch history and resource data.

Top module: `trace_msg_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: While a message is being emitted, `in_ready` is 0 and no new request is taken. A word offered with `out_ready` low stays unchanged on the next cycle.
- R3: The header bit stream is the type code in bits 0..5, then the low `in_fix0_len` bits of `in_fix0`, then the low `in_fix1_len` bits of `in_fix1`. Fixed-field bits at or above the stated length are ignored. Slice s of the header carries header bits 6s..6s+5 in `out_word[5:0]`, least significant bit first.
- R4: The header takes ceil((6 + fix0 length + fix1 length) / 6) words. Each length is 0 to 6.
- R5: Variable value k starts on a new word and is emitted least significant bit first, 6 bits per word. It takes max(1, ceil((h+1)/6)) words, where h is the index of its highest set bit. A zero value takes one word.
- R6: Markers are in `out_word[7:6]`. The final word of a message carries 11, and no other word does. The last word of a variable value that is not the final word carries 01. Every other word carries 00, including the last header word when variable values follow.
- R7: Only the first `in_var_cnt` values (0 to 3) of `in_vars` are emitted, with value 0 in bits 63:0. Entries beyond the count have no effect. With a count of 0, the header alone forms the message.
- R8: The cycle after the final word is taken, `out_valid` is 0 and `in_ready` is 1.
- R9: A request is taken on the rising edge where `in_valid` and `in_ready` are both high. The first word of that request is offered on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Packer idle and able to take a request |
| in_type | input | 6 | Message type code |
| in_fix0_len | input | 3 | Width of first fixed field (0..6) |
| in_fix0 | input | 6 | First fixed field value |
| in_fix1_len | input | 3 | Width of second fixed field (0..6) |
| in_fix1 | input | 6 | Second fixed field value |
| in_var_cnt | input | 2 | Number of variable values to emit (0..3) |
| in_vars | input | 192 | Variable values, value k in bits 64k+63:64k |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 8 | {marker[1:0], data slice[5:0]} |

## Verification
The hardest case to reach from the ports is a variable value whose highest set bit lands exactly on a slice boundary, and in particular a full 64-bit value whose top slice is only partly used. Random values are shifted right by a random amount from 0 to 64, so every highest-bit position is hit, including zero. A directed sync-style message, with a zero count and an all-ones address, checks the total of 14 words and the exact words at the header, the count and the final slice. Random back-pressure and requests held on the input while busy make sure that stalls and unused input changes leave the stream unchanged.

// File: rtl/trace_msg_pkg.sv
package trace_msg_pkg;
    localparam int SLICE_W = 6;
    localparam int MARK_W  = 2;

    typedef enum logic [MARK_W-1:0] {
        MK_MID   = 2'b00,
        MK_FIELD = 2'b01,
        MK_EOM   = 2'b11
    } mark_e;
endpackage

// File: rtl/trace_msg_hdr.sv
module trace_msg_hdr #(
    parameter int TYPE_W  = 6,
    parameter int FIX_MAX = 6,
    parameter int FLEN_W  = 3,
    parameter int HDR_W   = 18,
    parameter int CNT_W   = 4
) (
    input  logic [TYPE_W-1:0]  type_i,
    input  logic [FLEN_W-1:0]  f0_len_i,
    input  logic [FIX_MAX-1:0] f0_i,
    input  logic [FLEN_W-1:0]  f1_len_i,
    input  logic [FIX_MAX-1:0] f1_i,
    output logic [HDR_W-1:0]   hdr_o,
    output logic [CNT_W-1:0]   nslc_o
);
    import trace_msg_pkg::*;

    logic [FIX_MAX-1:0] f0_m, f1_m;
    logic [HDR_W-1:0]   f0_w, f1_w;
    int                 nbits;

    always_comb begin
        for (int i = 0; i < FIX_MAX; i++) begin
            f0_m[i] = f0_i[i] & (i < int'(f0_len_i));
            f1_m[i] = f1_i[i] & (i < int'(f1_len_i));
        end
        f0_w   = HDR_W'(f0_m) << TYPE_W;
        f1_w   = HDR_W'(f1_m) << (TYPE_W + int'(f0_len_i));
        hdr_o  = HDR_W'(type_i) | f0_w | f1_w;
        nbits  = TYPE_W + int'(f0_len_i) + int'(f1_len_i);
        nslc_o = CNT_W'((nbits + SLICE_W - 1) / SLICE_W);
    end
endmodule

// File: rtl/trace_msg_varlen.sv
module trace_msg_varlen #(
    parameter int VAL_W = 64,
    parameter int CNT_W = 4
) (
    input  logic [VAL_W-1:0] val_i,
    output logic [CNT_W-1:0] nslc_o
);
    import trace_msg_pkg::*;

    always_comb begin
        nslc_o = CNT_W'(1);
        for (int i = 0; i < VAL_W; i++) begin
            if (val_i[i]) nslc_o = CNT_W'(i / SLICE_W + 1);
        end
    end
endmodule

// File: rtl/trace_msg_packer.sv
module trace_msg_packer #(
    parameter int TYPE_W  = 6,
    parameter int FIX_MAX = 6,
    parameter int VAR_W   = 64,
    parameter int NVAR    = 3,
    localparam int FLEN_W = $clog2(FIX_MAX + 1),
    localparam int SEG_W  = $clog2(NVAR + 1),
    localparam int WORD_W = trace_msg_pkg::SLICE_W + trace_msg_pkg::MARK_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [TYPE_W-1:0]     in_type,
    input  logic [FLEN_W-1:0]     in_fix0_len,
    input  logic [FIX_MAX-1:0]    in_fix0,
    input  logic [FLEN_W-1:0]     in_fix1_len,
    input  logic [FIX_MAX-1:0]    in_fix1,
    input  logic [SEG_W-1:0]      in_var_cnt,
    input  logic [NVAR*VAR_W-1:0] in_vars,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [WORD_W-1:0]     out_word
);
    import trace_msg_pkg::*;

    localparam int HDR_W   = TYPE_W + 2 * FIX_MAX;
    localparam int HDR_SLC = (HDR_W + SLICE_W - 1) / SLICE_W;
    localparam int VAR_SLC = (VAR_W + SLICE_W - 1) / SLICE_W;
    localparam int MAX_SLC = (HDR_SLC > VAR_SLC) ? HDR_SLC : VAR_SLC;
    localparam int CNT_W   = $clog2(MAX_SLC + 1);
    localparam int SHIFT_W = MAX_SLC * SLICE_W;

    typedef struct packed {
        logic                            busy;
        logic [SEG_W-1:0]                seg;
        logic [SEG_W-1:0]                last;
        logic [CNT_W-1:0]                left;
        logic [SHIFT_W-1:0]              cur;
        logic [NVAR-1:0][VAR_W-1:0]      vals;
        logic [NVAR-1:0][CNT_W-1:0]      lens;
    } state_t;

    state_t state_d, state_q;

    logic [HDR_W-1:0]            hdr;
    logic [CNT_W-1:0]            hdr_n;
    logic [NVAR-1:0][CNT_W-1:0]  var_n;
    logic [SEG_W-1:0]            cnt_clip;
    mark_e                       mark;

    trace_msg_hdr #(
        .TYPE_W (TYPE_W),
        .FIX_MAX(FIX_MAX),
        .FLEN_W (FLEN_W),
        .HDR_W  (HDR_W),
        .CNT_W  (CNT_W)
    ) u_hdr (
        .type_i  (in_type),
        .f0_len_i(in_fix0_len),
        .f0_i    (in_fix0),
        .f1_len_i(in_fix1_len),
        .f1_i    (in_fix1),
        .hdr_o   (hdr),
        .nslc_o  (hdr_n)
    );

    for (genvar k = 0; k < NVAR; k++) begin : g_len
        trace_msg_varlen #(
            .VAL_W(VAR_W),
            .CNT_W(CNT_W)
        ) u_len (
            .val_i (in_vars[k*VAR_W +: VAR_W]),
            .nslc_o(var_n[k])
        );
    end

    always_comb begin
        cnt_clip = (int'(in_var_cnt) > NVAR) ? SEG_W'(NVAR) : in_var_cnt;
        state_d  = state_q;
        if (!state_q.busy) begin
            if (in_valid) begin
                state_d.busy = 1'b1;
                state_d.seg  = '0;
                state_d.last = cnt_clip;
                state_d.left = hdr_n;
                state_d.cur  = SHIFT_W'(hdr);
                for (int k = 0; k < NVAR; k++) begin
                    state_d.vals[k] = in_vars[k*VAR_W +: VAR_W];
                    state_d.lens[k] = var_n[k];
                end
            end
        end else if (out_ready) begin
            if (state_q.left > CNT_W'(1)) begin
                state_d.cur  = state_q.cur >> SLICE_W;
                state_d.left = state_q.left - CNT_W'(1);
            end else if (state_q.seg == state_q.last) begin
                state_d.busy = 1'b0;
            end else begin
                state_d.seg  = state_q.seg + SEG_W'(1);
                state_d.cur  = SHIFT_W'(state_q.vals[state_q.seg]);
                state_d.left = state_q.lens[state_q.seg];
            end
        end

        mark = MK_MID;
        if (state_q.left == CNT_W'(1)) begin
            if (state_q.seg == state_q.last) mark = MK_EOM;
            else if (state_q.seg != '0)      mark = MK_FIELD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign in_ready  = !state_q.busy;
    assign out_valid = state_q.busy;
    assign out_word  = {mark, state_q.cur[SLICE_W-1:0]};
endmodule

// File: rtl/trace_msg_packer_chk.sv
module trace_msg_packer_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word
);
    // R2: no request taken while emitting
    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R2: stalled word held
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    // R6: marker 10 never used
    a_r6_marker_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1 -: 2] != 2'b10);

    // R6: a taken word without end marker is followed by more words
    a_r6_eom_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_word[WORD_W-1 -: 2] != 2'b11 |=> out_valid);

    // R8: end of message frees the input
    a_r8_end_frees: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_word[WORD_W-1 -: 2] == 2'b11 |=> in_ready && !out_valid);

    // R9: taken request produces a word on the next cycle
    a_r9_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
endmodule

bind trace_msg_packer trace_msg_packer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_word (out_word)
);

// File: tb/trace_msg_packer_bench.sv
module trace_msg_packer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [5:0]   in_type = '0;
    logic [2:0]   in_fix0_len = '0;
    logic [5:0]   in_fix0 = '0;
    logic [2:0]   in_fix1_len = '0;
    logic [5:0]   in_fix1 = '0;
    logic [1:0]   in_var_cnt = '0;
    logic [191:0] in_vars = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_w [0:63];
    int         exp_n;
    logic [7:0] rx_w  [0:63];
    int         rx_n;

    always #4 clk = ~clk;

    trace_msg_packer u_trace_msg_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_fix0_len(in_fix0_len), .in_fix0(in_fix0),
        .in_fix1_len(in_fix1_len), .in_fix1(in_fix1), .in_var_cnt(in_var_cnt),
        .in_vars(in_vars), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected word list from the requirements (R3 R4 R5 R6 R7)
    task automatic build_expected();
        logic [17:0] hb;
        int pos, nh, n;
        logic [63:0] v;
        hb = '0; pos = 0; exp_n = 0;
        for (int i = 0; i < 6; i++) begin hb[pos] = in_type[i]; pos++; end
        for (int i = 0; i < int'(in_fix0_len); i++) begin hb[pos] = in_fix0[i]; pos++; end
        for (int i = 0; i < int'(in_fix1_len); i++) begin hb[pos] = in_fix1[i]; pos++; end
        nh = (pos + 5) / 6;
        for (int s = 0; s < nh; s++) begin
            exp_w[exp_n] = {((s == nh - 1) && in_var_cnt == 0) ? 2'b11 : 2'b00, hb[6*s +: 6]};
            exp_n++;
        end
        for (int k = 0; k < int'(in_var_cnt); k++) begin
            v = in_vars[64*k +: 64];
            n = 1;
            while (n < 11 && (v >> (6 * n)) != 64'd0) n++;
            for (int s = 0; s < n; s++) begin
                logic [1:0] m;
                m = 2'b00;
                if (s == n - 1) m = (k == int'(in_var_cnt) - 1) ? 2'b11 : 2'b01;
                exp_w[exp_n] = {m, 6'((v >> (6 * s)) & 64'h3F)};
                exp_n++;
            end
        end
    endtask

    task automatic send();
        @(negedge clk);
        build_expected();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv(input bit garbage, input int stall_pct);
        int idx = 0;
        bit stalled = 0;
        logic [7:0] pw = '0;
        rx_n = 0;
        if (garbage) begin
            in_valid = 1'b1;
            in_type = 6'($urandom);
            in_vars = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            in_var_cnt = 2'($urandom);
        end
        while (idx < exp_n) begin
            @(negedge clk);
            if (!out_valid) begin
                chk(0, "R9 word expected", 0, 1);
                break;
            end
            if (stalled) chk(out_word == pw, "R2 stalled word held", out_word, pw);
            if (garbage) chk(in_ready == 1'b0, "R2 busy blocks input", in_ready, 0);
            if (int'($urandom % 100) >= stall_pct) begin
                out_ready = 1'b1;
                chk(out_word == exp_w[idx], "R3 R5 R6 R7 word", out_word, exp_w[idx]);
                rx_w[rx_n] = out_word; rx_n++;
                idx++;
                stalled = 0;
            end else begin
                out_ready = 1'b0;
                stalled = 1;
                pw = out_word;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b0;
        chk(in_ready && !out_valid, "R8 idle after final word", {in_ready, out_valid}, 2'b10);
        chk(rx_n == exp_n, "R4 R5 word count", rx_n, exp_n);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", {in_ready, out_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle after reset", {in_ready, out_valid}, 2'b10);

        // sync-style: type 9, 4-bit reason 1, zero count, full address
        in_type = 6'd9; in_fix0_len = 3'd4; in_fix0 = 6'd1; in_fix1_len = 3'd0; in_fix1 = 6'h3F;
        in_var_cnt = 2'd2;
        in_vars = {64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0};
        send(); recv(0, 0);
        chk(rx_n == 14, "R4 R5 sync word count", rx_n, 14);
        chk(rx_w[0] == 8'h09, "R3 sync type slice", rx_w[0], 8'h09);
        chk(rx_w[1] == 8'h01, "R3 R6 sync reason slice", rx_w[1], 8'h01);
        chk(rx_w[2] == 8'h40, "R5 R6 zero count one word", rx_w[2], 8'h40);
        chk(rx_w[12] == 8'h3F, "R5 address middle slice", rx_w[12], 8'h3F);
        chk(rx_w[13] == 8'hCF, "R5 R6 address final partial slice", rx_w[13], 8'hCF);

        // type only, nothing else: one word with end marker (R7)
        in_type = 6'd33; in_fix0_len = 3'd0; in_fix1_len = 3'd0; in_var_cnt = 2'd0;
        in_vars = {64'h1, 64'h2, 64'h3};
        send(); recv(0, 30);
        chk(rx_n == 1 && rx_w[0] == 8'hE1, "R6 R7 single word message", rx_w[0], 8'hE1);

        // fixed bits above length ignored, 2-bit field (R3)
        in_type = 6'd4; in_fix0_len = 3'd2; in_fix0 = 6'h3F; in_fix1_len = 3'd0; in_var_cnt = 2'd0;
        send(); recv(0, 0);
        chk(rx_n == 2 && rx_w[1] == 8'hC3, "R3 fixed bits above length ignored", rx_w[1], 8'hC3);

        // widest header: three slices (R4)
        in_type = 6'h2A; in_fix0_len = 3'd6; in_fix0 = 6'h15; in_fix1_len = 3'd6; in_fix1 = 6'h3C;
        in_var_cnt = 2'd1; in_vars = {64'd0, 64'd0, 64'h3F};
        send(); recv(0, 0);
        chk(rx_n == 4 && rx_w[2] == 8'h3C && rx_w[3] == 8'hFF, "R4 three slice header", rx_w[3], 8'hFF);

        // value with highest bit at 6: two words (R5)
        in_fix0_len = 3'd0; in_fix1_len = 3'd0; in_var_cnt = 2'd1; in_vars = {128'd0, 64'h40};
        send(); recv(0, 0);
        chk(rx_n == 3 && rx_w[1] == 8'h00 && rx_w[2] == 8'hC1, "R5 slice boundary value", rx_w[2], 8'hC1);

        // random traffic
        for (int m = 0; m < 300; m++) begin
            in_type = 6'($urandom);
            in_fix0_len = 3'($urandom % 7);
            in_fix0 = 6'($urandom);
            in_fix1_len = 3'($urandom % 7);
            in_fix1 = 6'($urandom);
            in_var_cnt = 2'($urandom);
            for (int k = 0; k < 3; k++)
                in_vars[64*k +: 64] = {$urandom, $urandom} >> ($urandom % 65);
            send();
            recv(m % 3 == 0, 40);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule